// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the control waveforms that drive a passive-matrix (STN) or active-matrix (TFT) LCD panel. Two counters walk through the horizontal and vertical phases of a frame. Both counters advance only on cycles where the panel clock enable input is high. From the counter state the block derives five signals: the line signal, the frame signal, a shared bias / data-enable signal, a line-end pulse, and a gated panel clock enable. In TFT mode the line and frame signals act as horizontal and vertical sync, and the shared signal marks visible pixels. In STN mode the line and frame signals act as line and frame pulses, and the shared signal is an AC-bias drive that toggles every N frames.

A pixel-request strobe tells the data path when a pixel must be presented. A one-cycle interrupt fires when the vertical counter enters a selected phase, which gives software a safe point to swap the frame base address. The block also sequences panel power: an enable starts the timing, a power request then raises the panel power output, and the data bus is released only at the next frame start.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each line runs through sync, back porch, active and front porch. These phases last `h_sync_i`, `h_back_i`, `h_active_i` and `h_front_i` panel clocks, and a length of 0 counts as 1. `line_o` is active during the horizontal sync phase.
- R2: The frame runs through sync, back porch, active and front porch lines with lengths `v_sync_i`, `v_back_i`, `v_active_i` and `v_front_i`. The vertical counter advances once per completed line. `frame_o` is active during the vertical sync lines.
- R3: With `tft_i`=1, `bias_de_o` is active exactly while both counters are in their active phases. `pix_req_o` is high in each clock cycle where `pclk_en_i` is high at such a position.
- R4: `pol_i` bit 0 inverts `line_o`, bit 1 inverts `frame_o` and bit 2 inverts `bias_de_o`. A bit value of 1 makes the signal active-low.
- R5: With `tft_i`=0, `bias_de_o` is a bias level. It starts at 0 when enabled and toggles at the end of every `bias_frames_i` frames, with 0 treated as 1.
- R6: `line_end_o` is high for the first panel clock of the horizontal front porch on every active line, and at no other time.
- R7: `irq_o` is high for one cycle when the vertical counter enters the phase selected by `irq_sel_i` (0 sync, 1 back porch, 2 active, 3 front porch). It is high in the first cycle that shows the new phase.
- R8: `power_o` rises one clock after `power_i` is set while enabled. `data_bus_en_o` then rises only after the next frame end. On clearing `power_i`, `data_bus_en_o` drops at the next clock and `power_o` drops at the following frame end.
- R9: While `enable_i` is 0, the line, frame and bias outputs sit at their inactive polarity levels. `line_end_o`, `pix_req_o`, `panel_clk_en_o`, `irq_o`, `power_o` and `data_bus_en_o` are 0. On re-enable both counters restart at the first sync position.
- R10: `panel_clk_en_o` follows `pclk_en_i` while enabled in TFT mode. In STN mode it follows `pclk_en_i` only at active pixels of active lines.
- R11: Counter state and the outputs derived from it change only on cycles where `pclk_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Timing enable |
| power_i | input | 1 | Panel power request |
| tft_i | input | 1 | 1 = TFT, 0 = STN |
| pclk_en_i | input | 1 | Panel clock tick |
| pol_i | input | 3 | Polarity: bit0 line, bit1 frame, bit2 bias/DE (1 = active-low) |
| irq_sel_i | input | 2 | Vertical phase that raises the interrupt |
| bias_frames_i | input | BIAS_W | Frames between bias toggles |
| h_sync_i | input | H_W | Horizontal sync length |
| h_back_i | input | H_W | Horizontal back porch length |
| h_active_i | input | H_W | Pixels per line |
| h_front_i | input | H_W | Horizontal front porch length |
| v_sync_i | input | V_W | Vertical sync lines |
| v_back_i | input | V_W | Vertical back porch lines |
| v_active_i | input | V_W | Lines per panel |
| v_front_i | input | V_W | Vertical front porch lines |
| line_o | output | 1 | Horizontal sync / line pulse |
| frame_o | output | 1 | Vertical sync / frame pulse |
| bias_de_o | output | 1 | Data enable (TFT) / AC bias (STN) |
| line_end_o | output | 1 | End-of-line pulse |
| panel_clk_en_o | output | 1 | Gated panel clock enable |
| pix_req_o | output | 1 | Pixel request strobe |
| irq_o | output | 1 | Vertical event interrupt pulse |
| power_o | output | 1 | Panel power enable |
| data_bus_en_o | output | 1 | Panel data bus enable |

## Verification
The bench keeps the default field widths: 11 bits horizontal, 10 bits vertical and 8 bits for the bias count. These widths cover the full 1024 by 768 range. It then programs frames of only 63 to 84 panel clocks. With frames that short, several whole frames fit in each run. That makes reachable the bias toggles at two-frame intervals and the zero-count case. It also reaches frame-end wraps of both counters, every interrupt phase selection, and the frame-aligned power sequencing. Tick gaps of zero, one and two idle clocks show that state advances only on ticks.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } phase_e;

  localparam int POL_LINE  = 0;
  localparam int POL_FRAME = 1;
  localparam int POL_BIAS  = 2;
  localparam int POL_BITS  = 3;
endpackage

// File: rtl/lcd_tg_axis.sv
// One timing axis: four consecutive phases, each a programmable length.
// Used for both the horizontal (R1) and the vertical (R2) dimension.
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_front,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          wrap_o
);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cur_len;
  logic [CW:0]   cnt_inc;
  logic          last;

  always_comb begin
    unique case (phase_q)
      PH_SYNC:   cur_len = len_sync;
      PH_BACK:   cur_len = len_back;
      PH_ACTIVE: cur_len = len_act;
      default:   cur_len = len_front;
    endcase
  end

  // a zero length behaves as a length of one
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign last    = (cnt_inc >= {1'b0, cur_len});

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (clr) begin
      phase_d = PH_SYNC;
      cnt_d   = '0;
    end else if (step) begin
      if (last) begin
        cnt_d   = '0;
        phase_d = phase_e'(phase_q + 2'd1);
      end else begin
        cnt_d = cnt_inc[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign last_o  = last;
  assign wrap_o  = step & ~clr & last & (phase_q == PH_FRONT);

  // R1 / R2: phases only ever advance to their successor
  a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && (phase_q != $past(phase_q))) |-> (phase_q == phase_e'($past(phase_q) + 2'd1)));

  // R11: no tick, no movement
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step) && !$past(clr)) |-> ($stable(cnt_q) && $stable(phase_q)));

  // R9: a clear restarts the axis at the first sync position
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> ((phase_q == PH_SYNC) && (cnt_q == '0)));

endmodule

// File: rtl/lcd_tg_bias.sv
// AC-bias level for passive panels: toggles every n frames (R5).
module lcd_tg_bias #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          frame_done,
  input  logic [NW-1:0] n_frames,
  output logic          bias_o
);

  logic [NW-1:0] fcnt_q, fcnt_d;
  logic [NW:0]   fcnt_inc;
  logic          bias_q, bias_d;

  assign fcnt_inc = {1'b0, fcnt_q} + 1'b1;

  always_comb begin
    fcnt_d = fcnt_q;
    bias_d = bias_q;
    if (clr) begin
      fcnt_d = '0;
      bias_d = 1'b0;
    end else if (frame_done) begin
      if (fcnt_inc >= {1'b0, n_frames}) begin
        fcnt_d = '0;
        bias_d = ~bias_q;
      end else begin
        fcnt_d = fcnt_inc[NW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      bias_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      bias_q <= bias_d;
    end
  end

  assign bias_o = bias_q;

  // R5: the level only changes at a frame boundary
  a_r5_toggle_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && (bias_q != $past(bias_q))) |-> $past(frame_done));

endmodule

// File: rtl/lcd_tg_power.sv
// Panel power and data-bus release sequencing (R8).
module lcd_tg_power (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic power_req,
  input  logic frame_start,
  output logic pwr_o,
  output logic data_en_o
);

  logic pwr_q, pwr_d;
  logic dat_q, dat_d;

  always_comb begin
    pwr_d = enable & (power_req | (pwr_q & ~frame_start));
    dat_d = enable & power_req & pwr_q & (dat_q | frame_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      pwr_q <= pwr_d;
      dat_q <= dat_d;
    end
  end

  assign pwr_o     = pwr_q;
  assign data_en_o = dat_q;

  // R8: data bus is never live without panel power
  a_r8_data_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    data_en_o |-> pwr_o);

  // R8: the data bus is only released at a frame boundary
  a_r8_data_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_en_o) |-> $past(frame_start));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int H_W    = 11,
  parameter int V_W    = 10,
  parameter int BIAS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              power_i,
  input  logic              tft_i,
  input  logic              pclk_en_i,
  input  logic [2:0]        pol_i,
  input  logic [1:0]        irq_sel_i,
  input  logic [BIAS_W-1:0] bias_frames_i,
  input  logic [H_W-1:0]    h_sync_i,
  input  logic [H_W-1:0]    h_back_i,
  input  logic [H_W-1:0]    h_active_i,
  input  logic [H_W-1:0]    h_front_i,
  input  logic [V_W-1:0]    v_sync_i,
  input  logic [V_W-1:0]    v_back_i,
  input  logic [V_W-1:0]    v_active_i,
  input  logic [V_W-1:0]    v_front_i,
  output logic              line_o,
  output logic              frame_o,
  output logic              bias_de_o,
  output logic              line_end_o,
  output logic              panel_clk_en_o,
  output logic              pix_req_o,
  output logic              irq_o,
  output logic              power_o,
  output logic              data_bus_en_o
);

  logic           clr, tick;
  phase_e         h_phase, v_phase;
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  logic           h_last, h_wrap, v_last, v_wrap;
  logic           bias_lvl;
  logic           de_raw;
  logic [POL_BITS-1:0] sig_raw, sig_pin;
  logic           irq_q, irq_d;

  assign clr  = ~enable_i;
  assign tick = enable_i & pclk_en_i;

  lcd_tg_axis #(.CW(H_W)) u_h_axis (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .step      (tick),
    .len_sync  (h_sync_i),
    .len_back  (h_back_i),
    .len_act   (h_active_i),
    .len_front (h_front_i),
    .phase_o   (h_phase),
    .cnt_o     (h_cnt),
    .last_o    (h_last),
    .wrap_o    (h_wrap)
  );

  lcd_tg_axis #(.CW(V_W)) u_v_axis (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .step      (h_wrap),
    .len_sync  (v_sync_i),
    .len_back  (v_back_i),
    .len_act   (v_active_i),
    .len_front (v_front_i),
    .phase_o   (v_phase),
    .cnt_o     (v_cnt),
    .last_o    (v_last),
    .wrap_o    (v_wrap)
  );

  lcd_tg_bias #(.NW(BIAS_W)) u_bias (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .frame_done (v_wrap),
    .n_frames   (bias_frames_i),
    .bias_o     (bias_lvl)
  );

  lcd_tg_power u_power (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable_i),
    .power_req   (power_i),
    .frame_start (v_wrap),
    .pwr_o       (power_o),
    .data_en_o   (data_bus_en_o)
  );

  // visible pixel: both axes in their active phase
  assign de_raw = enable_i & (h_phase == PH_ACTIVE) & (v_phase == PH_ACTIVE);

  assign sig_raw[POL_LINE]  = enable_i & (h_phase == PH_SYNC);
  assign sig_raw[POL_FRAME] = enable_i & (v_phase == PH_SYNC);
  assign sig_raw[POL_BIAS]  = tft_i ? de_raw : (enable_i & bias_lvl);

  // per-signal polarity selection
  for (genvar gi = 0; gi < POL_BITS; gi++) begin : g_pol
    assign sig_pin[gi] = sig_raw[gi] ^ pol_i[gi];
  end

  assign line_o    = sig_pin[POL_LINE];
  assign frame_o   = sig_pin[POL_FRAME];
  assign bias_de_o = sig_pin[POL_BIAS];

  assign line_end_o = enable_i & (h_phase == PH_FRONT) & (h_cnt == '0)
                    & (v_phase == PH_ACTIVE);
  assign pix_req_o      = tick & de_raw;
  assign panel_clk_en_o = tick & (tft_i | de_raw);

  // interrupt on entry into the selected vertical phase
  always_comb begin
    irq_d = 1'b0;
    if (!clr) begin
      irq_d = h_wrap & v_last & (phase_e'(v_phase + 2'd1) == phase_e'(irq_sel_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R7: the interrupt is a single-cycle pulse
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R7: it coincides with the first cycle of a new vertical phase
  a_r7_irq_on_phase_entry: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (v_phase != $past(v_phase)));

  // R9: a disabled block keeps interrupt and power outputs low
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!irq_o && !power_o && !data_bus_en_o));

  // R6: line end falls outside the visible pixels
  a_r6_line_end_not_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_o |-> !pix_req_o);

endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;

  logic        clk;
  logic        rst_n;
  logic        enable, power, tft, pclk_en;
  logic [2:0]  pol;
  logic [1:0]  isel_v;
  logic [7:0]  nbias;
  logic [10:0] hs_v, hb_v, ha_v, hf_v;
  logic [9:0]  vs_v, vb_v, va_v, vf_v;
  logic line_o, frame_o, bias_de_o, line_end_o, panel_clk_en_o, pix_req_o;
  logic irq_o, power_o, data_bus_en_o;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 0;
  int HS, HB, HA, HF, VS, VB, VA, VF, NB, GAP, ISEL;
  bit STN;
  logic [6:0] sb_q[$];
  logic [6:0] act_v, exp_v;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .power_i(power), .tft_i(tft),
    .pclk_en_i(pclk_en), .pol_i(pol), .irq_sel_i(isel_v), .bias_frames_i(nbias),
    .h_sync_i(hs_v), .h_back_i(hb_v), .h_active_i(ha_v), .h_front_i(hf_v),
    .v_sync_i(vs_v), .v_back_i(vb_v), .v_active_i(va_v), .v_front_i(vf_v),
    .line_o(line_o), .frame_o(frame_o), .bias_de_o(bias_de_o), .line_end_o(line_end_o),
    .panel_clk_en_o(panel_clk_en_o), .pix_req_o(pix_req_o), .irq_o(irq_o),
    .power_o(power_o), .data_bus_en_o(data_bus_en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input int b);
    case (b)
      6: return "R1 line";
      5: return "R2 frame";
      4: return STN ? "R5 bias" : "R3 data-enable";
      3: return "R6 line-end";
      2: return "R3 pixel-request";
      1: return "R10 panel-clock";
      default: return "R7 irq";
    endcase
  endfunction

  // expected output vector for the p-th tick position after enable
  function automatic logic [6:0] expect_at(input int p);
    int htot, vtot, flen, h, ln, fr, nn, start;
    bit hs_, ha_, hf0, vs_, va_, bias, irq;
    htot = HS + HB + HA + HF;
    vtot = VS + VB + VA + VF;
    flen = htot * vtot;
    h  = p % htot;
    ln = (p / htot) % vtot;
    fr = p / flen;
    hs_ = h < HS;
    ha_ = (h >= HS + HB) && (h < HS + HB + HA);
    hf0 = (h == HS + HB + HA);
    vs_ = ln < VS;
    va_ = (ln >= VS + VB) && (ln < VS + VB + VA);
    nn  = (NB == 0) ? 1 : NB;
    bias = STN ? (((fr / nn) % 2) == 1) : (ha_ && va_);
    case (ISEL)
      0: start = 0;
      1: start = VS;
      2: start = VS + VB;
      default: start = VS + VB + VA;
    endcase
    irq = (GAP == 0) && (p > 0) && (h == 0) && (ln == start);
    return {hs_ ^ pol[0], vs_ ^ pol[1], bias ^ pol[2], hf0 && va_, ha_ && va_,
            STN ? (ha_ && va_) : 1'b1, irq};
  endfunction

  // scoreboard monitor: one expected item per tick cycle
  always @(negedge clk) begin
    if (mon_on && pclk_en) begin
      act_v = {line_o, frame_o, bias_de_o, line_end_o, pix_req_o, panel_clk_en_o, irq_o};
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R1 scoreboard empty actual=%b expected=none", act_v);
      end else begin
        exp_v = sb_q.pop_front();
        if (act_v !== exp_v) begin
          fails++;
          for (int b = 6; b >= 0; b--)
            if (act_v[b] !== exp_v[b])
              $display("FAIL %s (R4 pol=%b) actual=%b expected=%b", tag_of(b), pol, act_v[b], exp_v[b]);
        end
      end
    end
  end

  task automatic step_clk();
    @(posedge clk);
    #1;
  endtask

  task automatic configure(input bit stn_m, input logic [2:0] pl, input int isel, input int nb,
                           input int hs, input int hb, input int ha, input int hf,
                           input int vs, input int vb, input int va, input int vf);
    enable = 1'b0;
    step_clk();
    STN = stn_m; tft = ~stn_m; pol = pl; ISEL = isel; NB = nb;
    HS = hs; HB = hb; HA = ha; HF = hf; VS = vs; VB = vb; VA = va; VF = vf;
    isel_v = 2'(isel); nbias = 8'(nb);
    hs_v = 11'(hs); hb_v = 11'(hb); ha_v = 11'(ha); hf_v = 11'(hf);
    vs_v = 10'(vs); vb_v = 10'(vb); va_v = 10'(va); vf_v = 10'(vf);
    step_clk();
    enable = 1'b1;
  endtask

  // driver: pushes expected items and issues ticks
  task automatic drive_ticks(input int n, input int gap);
    GAP = gap;
    mon_on = 1;
    for (int p = 0; p < n; p++) begin
      sb_q.push_back(expect_at(p));
      pclk_en = 1'b1;
      step_clk();
      if (gap > 0) begin
        pclk_en = 1'b0;
        repeat (gap) step_clk();
      end
    end
    pclk_en = 1'b0;
    step_clk();
    mon_on = 0;
    check("R11 scoreboard drained", sb_q.size(), 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pclk_en = 1'b1;
      step_clk();
      pclk_en = 1'b0;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; power = 1'b0; tft = 1'b1; pclk_en = 1'b0;
    pol = 3'b000; isel_v = 2'd0; nbias = 8'd1;
    hs_v = 11'd2; hb_v = 11'd3; ha_v = 11'd5; hf_v = 11'd2;
    vs_v = 10'd1; vb_v = 10'd2; va_v = 10'd3; vf_v = 10'd1;
    repeat (3) @(posedge clk);
    #1;
    // reset state (R9)
    check("R9 reset line_o", line_o, 0);
    check("R9 reset frame_o", frame_o, 0);
    check("R9 reset power_o", power_o, 0);
    check("R9 reset data_bus_en_o", data_bus_en_o, 0);
    check("R7 reset irq_o", irq_o, 0);
    rst_n = 1'b1;
    step_clk();

    // TFT, active-high, back-to-back ticks, irq at sync (R1 R2 R3 R6 R7 R10)
    configure(0, 3'b000, 0, 1, 2, 3, 5, 2, 1, 2, 3, 1);
    drive_ticks(2 * 84, 0);

    // TFT, all inverted (R4), idle gaps between ticks (R11), irq at active
    configure(0, 3'b111, 2, 1, 2, 3, 5, 2, 1, 2, 3, 1);
    drive_ticks(84, 2);

    // STN, bias every 2 frames (R5), irq at front porch, other timings
    configure(1, 3'b000, 3, 2, 1, 1, 4, 3, 2, 1, 2, 2);
    drive_ticks(5 * 63, 0);

    // STN, zero frame count behaves as one (R5), inverted bias (R4), irq at back porch
    configure(1, 3'b100, 1, 0, 2, 3, 5, 2, 1, 2, 3, 1);
    drive_ticks(3 * 84, 1);

    // STN, back-to-back, irq at back porch (R7)
    configure(1, 3'b000, 1, 3, 2, 3, 5, 2, 1, 2, 3, 1);
    drive_ticks(2 * 84, 0);

    // power sequencing (R8), TFT timings of 84 ticks per frame
    configure(0, 3'b000, 0, 1, 2, 3, 5, 2, 1, 2, 3, 1);
    power = 1'b1;
    step_clk();
    step_clk();
    check("R8 power_o rises", power_o, 1);
    check("R8 data bus held", data_bus_en_o, 0);
    ticks(83);
    check("R8 data bus before frame end", data_bus_en_o, 0);
    ticks(1);
    check("R8 data bus after frame end", data_bus_en_o, 1);
    power = 1'b0;
    step_clk();
    check("R8 data bus drops first", data_bus_en_o, 0);
    check("R8 power stays", power_o, 1);
    ticks(83);
    check("R8 power before frame end", power_o, 1);
    ticks(1);
    check("R8 power after frame end", power_o, 0);

    // disable mid-frame (R9) with active-low line/frame (R4)
    configure(0, 3'b011, 0, 1, 2, 3, 5, 2, 1, 2, 3, 1);
    ticks(30);
    power = 1'b1;
    step_clk();
    step_clk();
    enable = 1'b0;
    pclk_en = 1'b1;
    @(negedge clk);
    check("R9 line inactive", line_o, 1);
    check("R9 frame inactive", frame_o, 1);
    check("R9 bias inactive", bias_de_o, 0);
    check("R9 pixel request off", pix_req_o, 0);
    check("R9 panel clock off", panel_clk_en_o, 0);
    check("R9 line end off", line_end_o, 0);
    step_clk();
    pclk_en = 1'b0;
    check("R9 power off", power_o, 0);
    check("R9 data bus off", data_bus_en_o, 0);
    check("R9 irq off", irq_o, 0);
    power = 1'b0;
    enable = 1'b1;
    #1;
    check("R9 restart at line sync", line_o, 0);
    check("R9 restart at frame sync", frame_o, 0);
    step_clk();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule